// File: doc/BRIEF.md
# Static Memory Strobe Timing Generator

This block drives the chip-select, read-strobe and write-strobe lines of an external static memory for one access at a time. A requester raises `req_i` with the address, byte enables, direction and chip-select index. The block acknowledges in the same cycle when it is idle. It then walks a counter through the access cycles and asserts each strobe inside a window. Each window is defined by a setup count and a pulse count. The total access length is set by a cycle count. Each chip select has its own set of counts, loaded through a simple configuration write port. Read data is captured when the read strobe releases. A one-cycle `done_o` pulse marks the last cycle of the access.

A separate `slow_clk_i` input tells the block that the system clock has been brought down to a very low rate. When it is high at the moment a request is accepted, the programmed counts of every chip select are set aside and a fixed built-in profile is used instead. A read then takes two cycles and a write takes three. The input is sampled only when an access starts, so an access already running keeps its profile.

The controller has two states. `ST_IDLE` moves to `ST_ACTIVE` when a request is accepted. `ST_ACTIVE` moves back to `ST_IDLE` after the last access cycle. Access cycle index k counts from 0, where 0 is the first cycle after the accepting clock edge.

Top module: `smc_strobe_gen`

## Requirements
- R1: Outside an access, all chip selects, `nrd_n_o` and `nwe_n_o` are high (all strobes active low). `ack_o` is high only in `ST_IDLE` while `req_i` is high, in the same cycle.
- R2: At most one chip-select line is low at any time, and it is always the line indexed by the accepted `cs_i`.
- R3: In a normal-mode read, the chip select is low in the cycles k with cs_setup <= k < cs_setup+cs_pulse, and `nrd_n_o` is low in the cycles k with setup <= k < setup+pulse. Both windows are cut off at the end of the access. A setup of 0 asserts the strobe in cycle 0.
- R4: A normal-mode write uses the write-phase counts of the selected chip select in the same way, driving `nwe_n_o`. `nrd_n_o` stays high during a write.
- R5: In slow mode, a read holds the chip select low in cycles 0 and 1, drives `nrd_n_o` low only in cycle 1, and lasts 2 cycles.
- R6: In slow mode, a write holds the chip select low in cycles 0 to 2, drives `nwe_n_o` low only in cycle 1, and lasts 3 cycles.
- R7: The slow profile applies on every chip select, whatever its programmed counts. `slow_clk_i` is sampled only at acceptance, so toggling it during an access changes nothing.
- R8: `done_o` is high for exactly one cycle, on cycle index max(cycle,1)-1. No request is acknowledged during an access. A new one can be accepted at the earliest in the cycle after `done_o`.
- R9: Read data on `rdata_i` is captured at the clock edge that ends the last cycle in which `nrd_n_o` is low. `rdata_o` holds it until the next capture, and a write leaves it unchanged.
- R10: `addr_o`, `be_o` and `we_o` carry the accepted request values and stay stable for the whole access.
- R11: A configuration write (`cfg_we_i`) stores `cfg_data_i` for chip select `cfg_sel_i`. The read phase is in bits 29:0 and the write phase in bits 59:30. Each phase packs, from LSB in 6-bit fields: setup, pulse, cs_setup, cs_pulse, cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk_i | input | 1 | System clock slowed; use fixed profile |
| cfg_we_i | input | 1 | Timing register write enable |
| cfg_sel_i | input | CSW | Chip select whose timing is written |
| cfg_data_i | input | 60 | Packed timing word (R11 layout) |
| req_i | input | 1 | Access request |
| ack_o | output | 1 | Request accepted this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| cs_i | input | CSW | Chip-select index of the request |
| addr_i | input | AW | Request address |
| be_i | input | BEW | Request byte enables |
| rdata_i | input | DW | Read data from memory |
| ncs_n_o | output | NCS | Chip selects, active low |
| nrd_n_o | output | 1 | Read strobe, active low |
| nwe_n_o | output | 1 | Write strobe, active low |
| addr_o | output | AW | Address to memory |
| be_o | output | BEW | Byte enables to memory |
| we_o | output | 1 | Direction of the current access |
| rdata_o | output | DW | Captured read data |
| done_o | output | 1 | Last cycle of the access |

## Verification
`ack_o` depends on `req_i` without a register, so it is sampled one time unit after the request is driven on the falling edge. Access cycle k of a request accepted at a rising edge is observed at the (k+1)-th falling edge after that edge. The scoreboard holds one expected item per access cycle and pops one at each falling edge. During that cycle it also drives `rdata_i` with a value that encodes k, which shows exactly which cycle was captured. `rdata_o` is compared at the falling edge after `done_o`, which is also where the idle levels and the next acceptance are checked.

// File: rtl/smc_pkg.sv
package smc_pkg;
    parameter int TCW = 6;

    typedef logic [TCW-1:0] cnt_t;

    // field order from MSB: cycle, cs_pulse, cs_setup, pulse, setup
    typedef struct packed {
        cnt_t cycle;
        cnt_t cs_pulse;
        cnt_t cs_setup;
        cnt_t pulse;
        cnt_t setup;
    } phase_t;

    typedef struct packed {
        phase_t wr;
        phase_t rd;
    } timing_t;

    localparam int PHASE_W  = $bits(phase_t);
    localparam int TIMING_W = $bits(timing_t);

    typedef enum logic {ST_IDLE, ST_ACTIVE} state_t;

    function automatic phase_t slow_phase(input logic wr);
        phase_t p;
        p.setup    = cnt_t'(1);
        p.pulse    = cnt_t'(1);
        p.cs_setup = cnt_t'(0);
        p.cs_pulse = wr ? cnt_t'(3) : cnt_t'(2);
        p.cycle    = wr ? cnt_t'(3) : cnt_t'(2);
        return p;
    endfunction

    function automatic timing_t reset_timing();
        timing_t t;
        t.rd.setup    = cnt_t'(0);
        t.rd.pulse    = cnt_t'(1);
        t.rd.cs_setup = cnt_t'(0);
        t.rd.cs_pulse = cnt_t'(1);
        t.rd.cycle    = cnt_t'(1);
        t.wr          = t.rd;
        return t;
    endfunction

    function automatic logic in_window(input cnt_t c, input cnt_t start, input cnt_t len);
        logic [TCW:0] cx, sx, ex;
        cx = {1'b0, c};
        sx = {1'b0, start};
        ex = sx + {1'b0, len};
        return (cx >= sx) && (cx < ex);
    endfunction
endpackage

// File: rtl/smc_timing_bank.sv
module smc_timing_bank #(
    parameter int NCS = 4,
    parameter int CSW = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [CSW-1:0]               wr_sel_i,
    input  logic [smc_pkg::TIMING_W-1:0] wr_data_i,
    input  logic [CSW-1:0]               rd_sel_i,
    output smc_pkg::timing_t             rd_timing_o
);
    import smc_pkg::*;

    timing_t bank_q [NCS];

    for (genvar g = 0; g < NCS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q[g] <= reset_timing();
            end else if (wr_en_i && (wr_sel_i == CSW'(g))) begin
                bank_q[g] <= timing_t'(wr_data_i);
            end
        end
    end

    assign rd_timing_o = bank_q[rd_sel_i];
endmodule

// File: rtl/smc_profile_sel.sv
module smc_profile_sel (
    input  logic             slow_i,
    input  logic             wr_i,
    input  smc_pkg::timing_t prog_i,
    output smc_pkg::phase_t  phase_o
);
    import smc_pkg::*;

    phase_t pick;

    always_comb begin
        if (slow_i) begin
            pick = slow_phase(wr_i);
        end else begin
            pick = wr_i ? prog_i.wr : prog_i.rd;
        end
        phase_o = pick;
        // an access lasts at least one cycle
        if (pick.cycle == '0) begin
            phase_o.cycle = cnt_t'(1);
        end
    end
endmodule

// File: rtl/smc_strobe_gen.sv
module smc_strobe_gen #(
    parameter int NCS = 4,
    parameter int AW  = 24,
    parameter int BEW = 2,
    parameter int DW  = 16,
    localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         slow_clk_i,
    input  logic                         cfg_we_i,
    input  logic [CSW-1:0]               cfg_sel_i,
    input  logic [smc_pkg::TIMING_W-1:0] cfg_data_i,
    input  logic                         req_i,
    output logic                         ack_o,
    input  logic                         we_i,
    input  logic [CSW-1:0]               cs_i,
    input  logic [AW-1:0]                addr_i,
    input  logic [BEW-1:0]               be_i,
    input  logic [DW-1:0]                rdata_i,
    output logic [NCS-1:0]               ncs_n_o,
    output logic                         nrd_n_o,
    output logic                         nwe_n_o,
    output logic [AW-1:0]                addr_o,
    output logic [BEW-1:0]               be_o,
    output logic                         we_o,
    output logic [DW-1:0]                rdata_o,
    output logic                         done_o
);
    import smc_pkg::*;

    state_t         state_q, state_nx;
    cnt_t           cnt_q;
    phase_t         ph_q, ph_next;
    timing_t        prog_t;
    logic           wr_q;
    logic [CSW-1:0] cs_q;
    logic [AW-1:0]  addr_q;
    logic [BEW-1:0] be_q;
    logic [DW-1:0]  rdata_q;
    logic           busy, last, accept;
    logic           cs_on, rd_on, wr_on, cap;
    logic [TCW:0]   rd_end;

    smc_timing_bank #(.NCS(NCS), .CSW(CSW)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (cfg_we_i),
        .wr_sel_i   (cfg_sel_i),
        .wr_data_i  (cfg_data_i),
        .rd_sel_i   (cs_i),
        .rd_timing_o(prog_t)
    );

    smc_profile_sel u_sel (
        .slow_i (slow_clk_i),
        .wr_i   (we_i),
        .prog_i (prog_t),
        .phase_o(ph_next)
    );

    assign busy   = (state_q == ST_ACTIVE);
    assign last   = busy && (cnt_q == (ph_q.cycle - cnt_t'(1)));
    assign accept = (state_q == ST_IDLE) && req_i;
    assign rd_end = {1'b0, ph_q.setup} + {1'b0, ph_q.pulse};

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_i) state_nx = ST_ACTIVE;
            ST_ACTIVE: if (last)  state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ph_q    <= reset_timing().rd;
            wr_q    <= 1'b0;
            cs_q    <= '0;
            addr_q  <= '0;
            be_q    <= '0;
            rdata_q <= '0;
        end else begin
            state_q <= state_nx;
            if (accept) begin
                cnt_q  <= '0;
                ph_q   <= ph_next;
                wr_q   <= we_i;
                cs_q   <= cs_i;
                addr_q <= addr_i;
                be_q   <= be_i;
            end else if (busy) begin
                cnt_q <= cnt_q + cnt_t'(1);
            end
            if (cap) begin
                rdata_q <= rdata_i;
            end
        end
    end

    always_comb begin
        ack_o   = accept;
        cs_on   = busy && in_window(cnt_q, ph_q.cs_setup, ph_q.cs_pulse);
        rd_on   = busy && !wr_q && in_window(cnt_q, ph_q.setup, ph_q.pulse);
        wr_on   = busy && wr_q && in_window(cnt_q, ph_q.setup, ph_q.pulse);
        cap     = rd_on && (({1'b0, cnt_q} == rd_end - 1'b1) || last);
        ncs_n_o = '1;
        if (cs_on) begin
            ncs_n_o[cs_q] = 1'b0;
        end
        nrd_n_o = !rd_on;
        nwe_n_o = !wr_on;
        done_o  = last;
        addr_o  = addr_q;
        be_o    = be_q;
        we_o    = wr_q;
        rdata_o = rdata_q;
    end
endmodule

// File: rtl/smc_strobe_chk.sv
module smc_strobe_chk #(
    parameter int NCS = 4,
    parameter int AW  = 24,
    parameter int BEW = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           req,
    input logic           ack,
    input logic           done,
    input logic [NCS-1:0] ncs_n,
    input logic           nrd_n,
    input logic           nwe_n,
    input logic [AW-1:0]  addr,
    input logic [BEW-1:0] be,
    input logic           we
);
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&ncs_n && nrd_n && nwe_n));

    a_r1_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> req);

    a_r2_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ncs_n));

    a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nrd_n && !nwe_n));

    a_r8_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ack);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r10_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(addr) && $stable(be) && $stable(we)));
endmodule

bind smc_strobe_gen smc_strobe_chk #(.NCS(NCS), .AW(AW), .BEW(BEW)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .busy (busy),
    .req  (req_i),
    .ack  (ack_o),
    .done (done_o),
    .ncs_n(ncs_n_o),
    .nrd_n(nrd_n_o),
    .nwe_n(nwe_n_o),
    .addr (addr_o),
    .be   (be_o),
    .we   (we_o)
);

// File: tb/sim_smc_strobe_gen.sv
module sim_smc_strobe_gen;
    localparam int CLK_PERIOD = 10;
    localparam int NCS = 4;
    localparam int CSW = 2;
    localparam int AW  = 24;
    localparam int BEW = 2;
    localparam int DW  = 16;
    localparam int TW  = 60;

    typedef struct packed {
        logic [NCS-1:0] ncs;
        logic           nrd;
        logic           nwe;
        logic           done;
        logic [DW-1:0]  rdv;
        logic [AW-1:0]  addr;
        logic [BEW-1:0] be;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slow_clk_i = 1'b0;
    logic cfg_we_i = 1'b0;
    logic [CSW-1:0] cfg_sel_i = '0;
    logic [TW-1:0] cfg_data_i = '0;
    logic req_i = 1'b0;
    logic we_i = 1'b0;
    logic [CSW-1:0] cs_i = '0;
    logic [AW-1:0] addr_i = '0;
    logic [BEW-1:0] be_i = '0;
    logic [DW-1:0] rdata_i = '0;
    logic ack_o, nrd_n_o, nwe_n_o, we_o, done_o;
    logic [NCS-1:0] ncs_n_o;
    logic [AW-1:0] addr_o;
    logic [BEW-1:0] be_o;
    logic [DW-1:0] rdata_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;
    item_t exp_q[$];
    string tag_q[$];
    int prog[NCS][2][5];     // [cs][wr][setup,pulse,cs_setup,cs_pulse,cycle]
    logic [DW-1:0] last_rd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smc_strobe_gen #(.NCS(NCS), .AW(AW), .BEW(BEW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .slow_clk_i(slow_clk_i),
        .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_data_i(cfg_data_i),
        .req_i(req_i), .ack_o(ack_o), .we_i(we_i), .cs_i(cs_i),
        .addr_i(addr_i), .be_i(be_i), .rdata_i(rdata_i),
        .ncs_n_o(ncs_n_o), .nrd_n_o(nrd_n_o), .nwe_n_o(nwe_n_o),
        .addr_o(addr_o), .be_o(be_o), .we_o(we_o), .rdata_o(rdata_o),
        .done_o(done_o)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // R11: pack per-chip-select counts into the configuration word
    task automatic program_cs(input int cs, input int r[5], input int w[5]);
        logic [TW-1:0] d;
        d = '0;
        for (int f = 0; f < 5; f++) begin
            d[6*f +: 6]      = 6'(r[f]);
            d[30 + 6*f +: 6] = 6'(w[f]);
            prog[cs][0][f]   = r[f];
            prog[cs][1][f]   = w[f];
        end
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_sel_i = CSW'(cs); cfg_data_i = d;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    // driver: one access, expected waveform pushed per cycle
    task automatic access(input int cs, input bit wr, input bit slow,
                          input bit flip, input logic [AW-1:0] a,
                          input logic [BEW-1:0] b, input string tag);
        int p[5];
        int ce, cap;
        logic [DW-1:0] base;
        item_t it;
        @(negedge clk);
        cs_i = CSW'(cs); we_i = wr; addr_i = a; be_i = b;
        slow_clk_i = slow; req_i = 1'b1;
        #1;
        check("R1", "ack when idle", 64'(ack_o), 64'd1);
        if (slow) begin
            p = wr ? '{1, 1, 0, 3, 3} : '{1, 1, 0, 2, 2};
        end else begin
            for (int f = 0; f < 5; f++) p[f] = prog[cs][wr][f];
        end
        ce = (p[4] == 0) ? 1 : p[4];
        base = DW'(16'h4000 + 16'h0100 * cs + (a[7:0] & 8'hF0));
        cap = -1;
        for (int k = 0; k < ce; k++) begin
            it.ncs = '1;
            it.ncs[cs] = !(k >= p[2] && k < p[2] + p[3]);
            it.nrd = !(!wr && k >= p[0] && k < p[0] + p[1]);
            it.nwe = !(wr && k >= p[0] && k < p[0] + p[1]);
            it.done = (k == ce - 1);
            it.rdv = base + DW'(k);
            it.addr = a;
            it.be = b;
            if (!it.nrd) cap = k;
            exp_q.push_back(it);
            tag_q.push_back(tag);
        end
        if (flip) begin
            @(negedge clk);
            slow_clk_i = !slow;
        end
        wait (exp_q.size() == 0);
        @(negedge clk);
        req_i = 1'b0;
        slow_clk_i = 1'b0;
        if (cap >= 0) last_rd = base + DW'(cap);
        check("R9", "captured read data", 64'(rdata_o), 64'(last_rd));
        check("R1", "chip selects idle", 64'(ncs_n_o), 64'({NCS{1'b1}}));
        check("R8", "done after access", 64'(done_o), 64'd0);
    endtask

    // monitor: one expected item per access cycle
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            item_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            rdata_i = e.rdv;
            #1;
            check(t, "ncs", 64'(ncs_n_o), 64'(e.ncs));
            check(t, "nrd", 64'(nrd_n_o), 64'(e.nrd));
            check(t, "nwe", 64'(nwe_n_o), 64'(e.nwe));
            check("R8", "done", 64'(done_o), 64'(e.done));
            check("R8", "no ack while busy", 64'(ack_o), 64'd0);
            check("R10", "addr", 64'(addr_o), 64'(e.addr));
            check("R10", "be", 64'(be_o), 64'(e.be));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int c = 0; c < NCS; c++)
            for (int w = 0; w < 2; w++)
                prog[c][w] = '{0, 1, 0, 1, 1};
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "reset ncs", 64'(ncs_n_o), 64'({NCS{1'b1}}));
        check("R1", "reset nrd", 64'(nrd_n_o), 64'd1);
        check("R1", "reset nwe", 64'(nwe_n_o), 64'd1);
        check("R8", "reset done", 64'(done_o), 64'd0);
        check("R1", "reset ack", 64'(ack_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        program_cs(0, '{2, 3, 1, 5, 7}, '{1, 2, 0, 4, 5});
        program_cs(2, '{0, 1, 0, 2, 3}, '{3, 2, 2, 4, 6});
        program_cs(3, '{0, 4, 0, 4, 0}, '{0, 4, 1, 9, 2});

        // R3/R4 normal mode on several chip selects (R11 layout)
        access(0, 0, 0, 0, 24'h0123A0, 2'b11, "R3/R11");
        access(0, 1, 0, 0, 24'h0456B0, 2'b01, "R4/R11");
        access(2, 0, 0, 0, 24'h1000C0, 2'b10, "R3");
        access(2, 1, 0, 0, 24'h2000D0, 2'b11, "R4");
        // cycle 0 treated as 1; windows clipped
        access(3, 0, 0, 0, 24'h3000E0, 2'b11, "R3/R8");
        access(3, 1, 0, 0, 24'h3100F0, 2'b01, "R4/R8");

        // R5/R6/R7 slow profile on programmed and unprogrammed chip selects
        access(0, 0, 1, 0, 24'h001110, 2'b11, "R5/R7");
        access(0, 1, 1, 0, 24'h002220, 2'b10, "R6/R7");
        access(1, 0, 1, 0, 24'h003330, 2'b01, "R5/R7");
        access(3, 1, 1, 0, 24'h004440, 2'b11, "R6/R7");

        // R7: toggling the slow indication mid-access has no effect
        access(0, 0, 0, 1, 24'h005550, 2'b11, "R3/R7");
        access(2, 1, 0, 1, 24'h006660, 2'b01, "R4/R7");
        access(1, 1, 1, 1, 24'h007770, 2'b10, "R6/R7");
        access(2, 0, 1, 1, 24'h008880, 2'b11, "R5/R7");

        // back in normal mode after slow accesses
        access(0, 0, 0, 0, 24'h0099A0, 2'b11, "R3/R7");

        repeat (2) @(negedge clk);
        summary();
    end
endmodule